// File: doc/BRIEF.md
# Display Power and Init Sequencer

This block brings up a small display controller over a register access engine. It drives a command port (operation, register index, write value, valid/ready handshake, done with error flag and read data) and never deals with serial bit timing itself. A start pulse begins initialisation. The block reads the identity register and checks it under a mask, then reads the status word. It then writes a fixed list of configuration registers, with the power-up steps placed partway through that list, and last selects the pixel memory data register.

Once initialisation ends, the block records the panel as unpowered and at once runs a power-up sequence of its own. After that a power request level sets the panel state. When the level differs from the recorded state, the matching power-up or power-down list runs. Waits between writes are whole milliseconds, counted from the system clock with the per-millisecond count rounded up.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset, busy, inited, powered, id_fail and cmd_valid are all low, and no command is issued until a request arrives.
- R2: Initialisation first issues a register read (op 1) of index 0x00. If the returned data ANDed with 0xFFF0 is not 0x9220, id_fail goes high, no further command is issued and inited stays low. The low four bits of the identity value do not take part in the comparison.
- R3: With a good identity, a status read (op 2, index 0x00) follows. Register writes (op 0) come next in a fixed order. The last command is an index-only select (op 3) of register 0x22.
- R4: The power-up steps are part of the initialisation list. They come after the write of 0x0110 to register 0x0C and before the first write to register 0x30. They are: 0x10=0000 (10 ms), 0x11=0000, 0x12=0000 (40 ms), 0x13=0000 (40 ms), 0x56=080F, 0x10=4240 (10 ms), 0x11=0000, 0x12=0014 (40 ms), 0x13=1319 (40 ms).
- R5: A write that carries a wait of N ms is followed by N*ceil(CLK_HZ/1000) idle cycles after its done. The next command is accepted exactly N*ceil(CLK_HZ/1000)+1 cycles after the done cycle. Without a wait, it is accepted in the cycle after done.
- R6: When initialisation completes, inited rises while powered is low. The power-up steps then run again on their own, and powered rises at their end.
- R7: With inited and powered both high, dropping pwr_req runs the power-down list: 0x10=0000 (10 ms), 0x11=0000, 0x12=0000 (40 ms), 0x13=0000 (40 ms). powered then falls.
- R8: A power list runs only once inited is high and pwr_req differs from powered. Before initialisation, pwr_req has no effect.
- R9: A done with cmd_err high aborts the running list. busy drops in the next cycle and powered keeps its old value. A power request that still differs from powered is then started again from its first step.
- R10: busy is high from the accepted request until the list ends, including the automatic power-up. init_req while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Start initialisation (pulse) |
| pwr_req | input | 1 | Requested panel power level |
| cmd_valid | output | 1 | Command offered to the access engine |
| cmd_ready | input | 1 | Access engine takes the command |
| cmd_op | output | 2 | 0 write, 1 register read, 2 status read, 3 index-only select |
| cmd_idx | output | 8 | Register index |
| cmd_wdata | output | 16 | Value for writes |
| cmd_done | input | 1 | Command finished (one cycle) |
| cmd_err | input | 1 | Command failed, valid with cmd_done |
| cmd_rdata | input | 16 | Read data, valid with cmd_done |
| busy | output | 1 | A list is running |
| inited | output | 1 | Initialisation completed |
| powered | output | 1 | Recorded panel power state |
| id_fail | output | 1 | Identity check failed |

## Verification
The bench records each accepted command together with its sampling cycle, and the cycle of the done that answered it. A command that follows a write with a wait must come exactly N*10+1 cycles after that done; at a 9.5 kHz setting this also tests the round-up to 10 cycles per millisecond. A command with no wait before it must come one cycle after the done. The flags are sampled on falling edges: busy, id_fail and inited once the block has been idle for five cycles, and powered at the moment the next list issues its first command. The abort and retry behaviour is checked by comparing the full command stream around the failed command.

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_req,
  input  logic        pwr_req,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_idx,
  output logic [15:0] cmd_wdata,
  input  logic        cmd_done,
  input  logic        cmd_err,
  input  logic [15:0] cmd_rdata,
  output logic        busy,
  output logic        inited,
  output logic        powered,
  output logic        id_fail
);
  localparam int CPM = (CLK_HZ + 999) / 1000;
  localparam int PW  = $clog2(CPM + 1);
  localparam logic [5:0] PON_AT   = 6'd13;
  localparam logic [5:0] POFF_END = 6'd17;
  localparam logic [5:0] PON_END  = 6'd22;
  localparam logic [5:0] INIT_END = 6'd40;

  typedef enum logic [1:0] {S_IDLE, S_ISS, S_WAIT, S_DLY} st_t;

  st_t          st;
  logic [5:0]   pc, stop, ms;
  logic [PW-1:0] pre;
  logic         auto_pon;
  logic [27:0]  cur;

  function automatic logic [27:0] step(input logic [5:0] a);
    case (a)
      6'd0:  step = {2'd1, 2'd0, 8'h00, 16'h0000};
      6'd1:  step = {2'd2, 2'd0, 8'h00, 16'h0000};
      6'd2:  step = {2'd0, 2'd1, 8'h00, 16'h0001};
      6'd3:  step = {2'd0, 2'd0, 8'h01, 16'h691B};
      6'd4:  step = {2'd0, 2'd0, 8'h02, 16'h0700};
      6'd5:  step = {2'd0, 2'd0, 8'h03, 16'h1030};
      6'd6:  step = {2'd0, 2'd0, 8'h04, 16'h0000};
      6'd7:  step = {2'd0, 2'd0, 8'h05, 16'h0000};
      6'd8:  step = {2'd0, 2'd0, 8'h07, 16'h0037};
      6'd9:  step = {2'd0, 2'd0, 8'h08, 16'h0202};
      6'd10: step = {2'd0, 2'd0, 8'h09, 16'h0000};
      6'd11: step = {2'd0, 2'd0, 8'h0B, 16'h0000};
      6'd12: step = {2'd0, 2'd0, 8'h0C, 16'h0110};
      6'd13: step = {2'd0, 2'd1, 8'h10, 16'h0000};
      6'd14: step = {2'd0, 2'd0, 8'h11, 16'h0000};
      6'd15: step = {2'd0, 2'd2, 8'h12, 16'h0000};
      6'd16: step = {2'd0, 2'd2, 8'h13, 16'h0000};
      6'd17: step = {2'd0, 2'd0, 8'h56, 16'h080F};
      6'd18: step = {2'd0, 2'd1, 8'h10, 16'h4240};
      6'd19: step = {2'd0, 2'd0, 8'h11, 16'h0000};
      6'd20: step = {2'd0, 2'd2, 8'h12, 16'h0014};
      6'd21: step = {2'd0, 2'd2, 8'h13, 16'h1319};
      6'd22: step = {2'd0, 2'd0, 8'h30, 16'h0302};
      6'd23: step = {2'd0, 2'd0, 8'h31, 16'h0407};
      6'd24: step = {2'd0, 2'd0, 8'h32, 16'h0304};
      6'd25: step = {2'd0, 2'd0, 8'h33, 16'h0203};
      6'd26: step = {2'd0, 2'd0, 8'h34, 16'h0706};
      6'd27: step = {2'd0, 2'd0, 8'h35, 16'h0407};
      6'd28: step = {2'd0, 2'd0, 8'h36, 16'h0706};
      6'd29: step = {2'd0, 2'd0, 8'h37, 16'h0000};
      6'd30: step = {2'd0, 2'd0, 8'h38, 16'h0C06};
      6'd31: step = {2'd0, 2'd0, 8'h39, 16'h0F00};
      6'd32: step = {2'd0, 2'd0, 8'h21, 16'h0000};
      6'd33: step = {2'd0, 2'd0, 8'h40, 16'h0000};
      6'd34: step = {2'd0, 2'd0, 8'h41, 16'h0000};
      6'd35: step = {2'd0, 2'd0, 8'h42, 16'hDB00};
      6'd36: step = {2'd0, 2'd0, 8'h43, 16'hDB00};
      6'd37: step = {2'd0, 2'd0, 8'h44, 16'hAF00};
      6'd38: step = {2'd0, 2'd0, 8'h45, 16'hDB00};
      6'd39: step = {2'd3, 2'd0, 8'h22, 16'h0000};
      default: step = '0;
    endcase
  endfunction

  assign cur       = step(pc);
  assign cmd_op    = cur[27:26];
  assign cmd_idx   = cur[23:16];
  assign cmd_wdata = cur[15:0];
  assign cmd_valid = (st == S_ISS);
  assign busy      = (st != S_IDLE) || auto_pon;

  wire [1:0] wc     = cur[25:24];
  wire       id_bad = (cmd_op == 2'd1) && ((cmd_rdata & 16'hFFF0) != 16'h9220);
  wire       last   = (pc + 6'd1) == stop;
  wire       go     = (st == S_WAIT && cmd_done && !cmd_err && !id_bad && wc == 2'd0) ||
                      (st == S_DLY && pre == PW'(CPM - 1) && ms == 6'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; stop <= '0; ms <= '0; pre <= '0;
      auto_pon <= 1'b0; inited <= 1'b0; powered <= 1'b0; id_fail <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (init_req) begin
            st <= S_ISS; pc <= '0; stop <= INIT_END;
            id_fail <= 1'b0; inited <= 1'b0; auto_pon <= 1'b0;
          end else if (inited && (auto_pon || pwr_req != powered)) begin
            st <= S_ISS; pc <= PON_AT; auto_pon <= 1'b0;
            stop <= (auto_pon || pwr_req) ? PON_END : POFF_END;
          end
        S_ISS:
          if (cmd_ready) st <= S_WAIT;
        S_WAIT:
          if (cmd_done) begin
            if (cmd_err) st <= S_IDLE;
            else if (id_bad) begin id_fail <= 1'b1; st <= S_IDLE; end
            else if (wc != 2'd0) begin
              st <= S_DLY; pre <= '0;
              ms <= (wc == 2'd1) ? 6'd10 : 6'd40;
            end
          end
        S_DLY:
          if (pre == PW'(CPM - 1)) begin pre <= '0; ms <= ms - 6'd1; end
          else pre <= pre + 1'b1;
        default: st <= S_IDLE;
      endcase
      if (go) begin
        if (last) begin
          st <= S_IDLE;
          if (stop == INIT_END) begin
            inited <= 1'b1; powered <= 1'b0; auto_pon <= 1'b1;
          end else powered <= (stop == PON_END);
        end else begin
          pc <= pc + 6'd1; st <= S_ISS;
        end
      end
    end
  end

  // R10
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> busy);
  // R2
  id_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) id_fail |-> !cmd_valid);
  // R9
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_err) |=> ($stable(powered) && !busy));
  // R6
  init_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inited) |-> (!powered && busy));
  // R3
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_idx) && $stable(cmd_wdata)));
endmodule

// File: tb/sim_disp_pwr_seq.sv
module sim_disp_pwr_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, init_req, pwr_req, cmd_valid, cmd_done, cmd_err;
  logic busy, inited, powered, id_fail;
  logic [1:0] cmd_op;
  logic [7:0] cmd_idx;
  logic [15:0] cmd_wdata, cmd_rdata;
  logic cmd_ready = 1'b1;

  disp_pwr_seq #(.CLK_HZ(9500)) u0 (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .pwr_req(pwr_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
    .cmd_err(cmd_err), .cmd_rdata(cmd_rdata), .busy(busy),
    .inited(inited), .powered(powered), .id_fail(id_fail));

  localparam int CPM = 10;
  int n_chk = 0, n_fail = 0, cyc = 0, nlog = 0, err_at = -1;
  logic [1:0]  lop [128];
  logic [7:0]  lidx[128];
  logic [15:0] lval[128];
  int lcyc[128], dcyc[128];
  logic [15:0] id_val = 16'h0;

  function automatic logic [31:0] exp_cmd(input int i);
    case (i)
      0:  return {2'd1, 6'd0,  8'h00, 16'h0000};
      1:  return {2'd2, 6'd0,  8'h00, 16'h0000};
      2:  return {2'd0, 6'd10, 8'h00, 16'h0001};
      3:  return {2'd0, 6'd0,  8'h01, 16'h691B};
      4:  return {2'd0, 6'd0,  8'h02, 16'h0700};
      5:  return {2'd0, 6'd0,  8'h03, 16'h1030};
      6:  return {2'd0, 6'd0,  8'h04, 16'h0000};
      7:  return {2'd0, 6'd0,  8'h05, 16'h0000};
      8:  return {2'd0, 6'd0,  8'h07, 16'h0037};
      9:  return {2'd0, 6'd0,  8'h08, 16'h0202};
      10: return {2'd0, 6'd0,  8'h09, 16'h0000};
      11: return {2'd0, 6'd0,  8'h0B, 16'h0000};
      12: return {2'd0, 6'd0,  8'h0C, 16'h0110};
      13: return {2'd0, 6'd10, 8'h10, 16'h0000};
      14: return {2'd0, 6'd0,  8'h11, 16'h0000};
      15: return {2'd0, 6'd40, 8'h12, 16'h0000};
      16: return {2'd0, 6'd40, 8'h13, 16'h0000};
      17: return {2'd0, 6'd0,  8'h56, 16'h080F};
      18: return {2'd0, 6'd10, 8'h10, 16'h4240};
      19: return {2'd0, 6'd0,  8'h11, 16'h0000};
      20: return {2'd0, 6'd40, 8'h12, 16'h0014};
      21: return {2'd0, 6'd40, 8'h13, 16'h1319};
      22: return {2'd0, 6'd0,  8'h30, 16'h0302};
      23: return {2'd0, 6'd0,  8'h31, 16'h0407};
      24: return {2'd0, 6'd0,  8'h32, 16'h0304};
      25: return {2'd0, 6'd0,  8'h33, 16'h0203};
      26: return {2'd0, 6'd0,  8'h34, 16'h0706};
      27: return {2'd0, 6'd0,  8'h35, 16'h0407};
      28: return {2'd0, 6'd0,  8'h36, 16'h0706};
      29: return {2'd0, 6'd0,  8'h37, 16'h0000};
      30: return {2'd0, 6'd0,  8'h38, 16'h0C06};
      31: return {2'd0, 6'd0,  8'h39, 16'h0F00};
      32: return {2'd0, 6'd0,  8'h21, 16'h0000};
      33: return {2'd0, 6'd0,  8'h40, 16'h0000};
      34: return {2'd0, 6'd0,  8'h41, 16'h0000};
      35: return {2'd0, 6'd0,  8'h42, 16'hDB00};
      36: return {2'd0, 6'd0,  8'h43, 16'hDB00};
      37: return {2'd0, 6'd0,  8'h44, 16'hAF00};
      38: return {2'd0, 6'd0,  8'h45, 16'hDB00};
      39: return {2'd3, 6'd0,  8'h22, 16'h0000};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  initial begin : responder
    int cnt = 0, cur = 0;
    cmd_done = 1'b0; cmd_err = 1'b0; cmd_rdata = 16'h0;
    forever begin
      @(negedge clk);
      cyc++;
      cmd_done = 1'b0; cmd_err = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          cmd_done = 1'b1;
          cmd_err = (cur == err_at);
          cmd_rdata = (lop[cur] == 2'd1) ? id_val : 16'h0;
          dcyc[cur] = cyc;
        end
      end
      if (cmd_valid && rst_n) begin
        cur = nlog;
        lop[cur] = cmd_op; lidx[cur] = cmd_idx; lval[cur] = cmd_wdata; lcyc[cur] = cyc;
        nlog++;
        cnt = 2;
      end
    end
  end

  task automatic wait_idle();
    int q = 0;
    while (q < 5) begin
      @(negedge clk);
      if (busy) q = 0; else q++;
    end
  endtask

  task automatic wait_log(input int n);
    while (nlog < n) @(negedge clk);
  endtask

  task automatic pulse_init();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
  endtask

  task automatic chk_stream(input int base, input int first, input int count, input string r);
    for (int j = 0; j < count; j++) begin
      logic [31:0] e;
      e = exp_cmd(first + j);
      chk({r, " op"},    {30'd0, lop[base + j]},  {30'd0, e[31:30]});
      chk({r, " index"}, {24'd0, lidx[base + j]}, {24'd0, e[23:16]});
      chk({r, " value"}, {16'd0, lval[base + j]}, {16'd0, e[15:0]});
      if (j > 0) begin
        logic [31:0] pe;
        pe = exp_cmd(first + j - 1);
        chk("R5 gap after done", lcyc[base + j] - dcyc[base + j - 1], pe[29:24] * CPM + 1);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int base;
    rst_n = 1'b0; init_req = 1'b0; pwr_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset flags", {28'd0, busy, inited, powered, id_fail}, 32'd0);
    chk("R1 no command", {31'd0, cmd_valid}, 32'd0);

    pwr_req = 1'b1;
    repeat (50) @(negedge clk);
    chk("R8 power before init", {31'd0, powered}, 32'd0);
    chk("R8 no command before init", nlog, 0);

    id_val = 16'h9310;
    pulse_init();
    wait_idle();
    chk("R2 single id read", nlog, 1);
    chk("R2 id read op", {30'd0, lop[0]}, 32'd1);
    chk("R2 id read index", {24'd0, lidx[0]}, 32'd0);
    chk("R2 id_fail", {31'd0, id_fail}, 32'd1);
    chk("R2 inited low", {31'd0, inited}, 32'd0);

    id_val = 16'h922A;
    base = nlog;
    pulse_init();
    repeat (20) @(negedge clk);
    chk("R10 busy during init", {31'd0, busy}, 32'd1);
    chk("R2 id_fail cleared", {31'd0, id_fail}, 32'd0);
    pulse_init();
    wait_log(base + 41);
    chk("R6 inited before auto power", {31'd0, inited}, 32'd1);
    chk("R6 recorded unpowered", {31'd0, powered}, 32'd0);
    chk("R10 busy in auto power", {31'd0, busy}, 32'd1);
    wait_idle();
    chk("R10 init_req ignored count", nlog, base + 49);
    chk_stream(base, 0, 40, "R3 init");
    chk("R4 interface before power", {24'd0, lidx[base + 12]}, 32'h0C);
    chk_stream(base + 13, 13, 9, "R4 embedded power");
    chk_stream(base + 40, 13, 9, "R6 auto power");
    chk("R6 powered", {31'd0, powered}, 32'd1);
    chk("R6 inited", {31'd0, inited}, 32'd1);

    base = nlog;
    pwr_req = 1'b0;
    wait_idle();
    chk("R7 power-down count", nlog, base + 4);
    chk_stream(base, 13, 4, "R7 power-down");
    chk("R7 powered low", {31'd0, powered}, 32'd0);

    base = nlog;
    err_at = base + 2;
    pwr_req = 1'b1;
    wait_log(base + 4);
    chk("R9 powered kept after abort", {31'd0, powered}, 32'd0);
    wait_idle();
    err_at = -1;
    chk("R9 abort and retry count", nlog, base + 12);
    chk_stream(base, 13, 3, "R9 aborted part");
    chk_stream(base + 3, 13, 9, "R9 retry");
    chk("R9 powered after retry", {31'd0, powered}, 32'd1);
    chk("R10 idle at end", {31'd0, busy}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule